// File: doc/BRIEF.md
# Half-Duplex Transmit Status Monitor

This block sits beside a half-duplex Ethernet transmitter and builds the status of each frame. It measures how long a pending frame waits while the medium is busy, and it can abort a frame that has waited too long. At 10 Mbps it also looks for the short collision pulse, the heartbeat, that a healthy transceiver returns just after a frame ends. Timing is counted in bit times through a one-cycle `bit_tick` strobe, so the same logic serves both line rates.

A transmit request starts a frame and clears the previous flags. While the frame is pending, each bit tick with carrier present counts towards the excessive-deferral limit. The limit is two maximum-size frame times: 24288 bit times, which is 2.4288 ms at 10 Mbps and 0.24288 ms at 100 Mbps. When carrier drops, the frame is taken as transmitting until the done strobe. The status is then reported with a one-cycle valid strobe. At 100 Mbps this happens on the next cycle. At 10 Mbps it happens once the heartbeat window has closed.

Top module: `tx_status_mon`

## Requirements
- R1: While reset is applied and after it is released, `no_hb`, `deferred`, `exc_defer`, `abort_p` and `stat_vld` are all low.
- R2: At 10 Mbps (`speed_10`=1) the heartbeat window opens on the cycle after `tx_done` and lasts `HB_WINDOW` bit ticks. A collision in the window closes it at once and reports `no_hb`=0. If no collision comes before the last tick, the status is reported with `no_hb`=1.
- R3: At 100 Mbps (`speed_10`=0) no heartbeat check is made. `stat_vld` rises on the cycle after `tx_done`, with `no_hb`=0.
- R4: In half duplex, carrier seen while the frame is pending sets `deferred` in the report. A collision at any point from the start of transmission up to and including the `tx_done` cycle clears it.
- R5: In half duplex, `exc_defer` rises when the number of bit ticks with carrier present while pending reaches `DEFER_LIMIT`.
- R6: If `tx_en_ctl` is low when `exc_defer` rises, the frame is aborted. `abort_p` and `stat_vld` are high together for that one cycle, and no transmission follows. If `tx_en_ctl` is high, the frame keeps waiting and is transmitted once carrier drops.
- R7: In full duplex (`half_duplex`=0), the frame goes straight to transmission, the deferral count stays at zero, and neither `deferred` nor `exc_defer` is ever set.
- R8: On the cycle after a `tx_req` accepted while idle, all three flags read low.
- R9: `stat_vld` is never high on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| speed_10 | input | 1 | 1 = 10 Mbps, 0 = 100 Mbps |
| half_duplex | input | 1 | 1 = half duplex, 0 = full duplex |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision |
| tx_en_ctl | input | 1 | Transmit-enable control bit; low allows abort on excessive deferral |
| tx_req | input | 1 | Strobe: a frame is pending |
| tx_done | input | 1 | Strobe: the frame's last bit has been sent |
| no_hb | output | 1 | No heartbeat seen after the frame |
| deferred | output | 1 | The frame waited on a busy medium without colliding |
| exc_defer | output | 1 | The wait reached the excessive-deferral limit |
| abort_p | output | 1 | One-cycle pulse: frame aborted |
| stat_vld | output | 1 | One-cycle pulse: flags hold this frame's status |

## Verification
The assertions assume that `speed_10` and `half_duplex` stay fixed from a frame's request to its report. They also assume that `tx_req` comes only while the block is idle and `tx_done` only while it is transmitting. The bench sets the mode inputs once per frame, before the request, and never changes them in mid-frame. It issues each request only after the previous report, and it pulses `tx_done` once per transmitted frame. It does not pulse `tx_done` for an aborted frame. Under these conditions the bench sweeps every mode combination against deferral lengths and collision placements on both sides of each limit.

// File: rtl/tx_status_mon.sv
module tx_status_mon #(
  parameter int DEFER_LIMIT = 24288,
  parameter int HB_WINDOW   = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic speed_10,
  input  logic half_duplex,
  input  logic crs,
  input  logic col,
  input  logic tx_en_ctl,
  input  logic tx_req,
  input  logic tx_done,
  output logic no_hb,
  output logic deferred,
  output logic exc_defer,
  output logic abort_p,
  output logic stat_vld
);
  localparam int DW = $clog2(DEFER_LIMIT + 1);
  localparam int HW = $clog2(HB_WINDOW + 1);

  typedef enum logic [1:0] {S_IDLE, S_PEND, S_TX, S_HB} st_t;

  st_t           st;
  logic [DW-1:0] dcnt;
  logic [HW-1:0] hcnt;
  logic          dseen, cseen;

  wire cseen_n = cseen | col;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      dcnt      <= '0;
      hcnt      <= '0;
      dseen     <= 1'b0;
      cseen     <= 1'b0;
      no_hb     <= 1'b0;
      deferred  <= 1'b0;
      exc_defer <= 1'b0;
      abort_p   <= 1'b0;
      stat_vld  <= 1'b0;
    end else begin
      abort_p  <= 1'b0;
      stat_vld <= 1'b0;
      case (st)
        S_IDLE: if (tx_req) begin
          st        <= S_PEND;
          dcnt      <= '0;
          dseen     <= 1'b0;
          cseen     <= 1'b0;
          no_hb     <= 1'b0;
          deferred  <= 1'b0;
          exc_defer <= 1'b0;
        end
        S_PEND: begin
          if (!half_duplex) begin
            st <= S_TX;
          end else if (crs) begin
            dseen <= 1'b1;
            if (bit_tick && !exc_defer) begin
              dcnt <= dcnt + 1'b1;
              if (dcnt == DW'(DEFER_LIMIT - 1)) begin
                exc_defer <= 1'b1;
                if (!tx_en_ctl) begin
                  st       <= S_IDLE;
                  abort_p  <= 1'b1;
                  stat_vld <= 1'b1;
                  deferred <= 1'b1;
                end
              end
            end
          end else begin
            st <= S_TX;
          end
        end
        S_TX: begin
          cseen <= cseen_n;
          if (tx_done) begin
            if (speed_10) begin
              st   <= S_HB;
              hcnt <= '0;
            end else begin
              st       <= S_IDLE;
              stat_vld <= 1'b1;
              deferred <= dseen & ~cseen_n;
            end
          end
        end
        S_HB: begin
          if (col || (bit_tick && hcnt == HW'(HB_WINDOW - 1))) begin
            st       <= S_IDLE;
            stat_vld <= 1'b1;
            deferred <= dseen & ~cseen;
            no_hb    <= ~col;
          end else if (bit_tick) begin
            hcnt <= hcnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  stat_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_vld |=> !stat_vld);

  // R6
  abort_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_p |-> (stat_vld && exc_defer));

  // R2
  nohb_speed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_vld && no_hb) |-> speed_10);

  // R7
  exc_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exc_defer) |-> half_duplex);

  // R5
  dcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dcnt <= DW'(DEFER_LIMIT));

  // R7
  fd_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PEND && !half_duplex) |=> (st == S_TX && dcnt == '0));
endmodule

// File: tb/tx_status_mon_bench.sv
module tx_status_mon_bench;
  localparam int CLK_PERIOD = 10;
  localparam int L = 20;
  localparam int W = 6;

  logic clk = 0, rst_n = 0;
  logic bit_tick = 1, speed_10 = 0, half_duplex = 1, crs = 0, col = 0;
  logic tx_en_ctl = 0, tx_req = 0, tx_done = 0;
  logic no_hb, deferred, exc_defer, abort_p, stat_vld;

  int checks = 0, fails = 0, cyc = 0;

  tx_status_mon #(.DEFER_LIMIT(L), .HB_WINDOW(W)) u_tx_status_mon (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .speed_10(speed_10),
    .half_duplex(half_duplex), .crs(crs), .col(col), .tx_en_ctl(tx_en_ctl),
    .tx_req(tx_req), .tx_done(tx_done), .no_hb(no_hb), .deferred(deferred),
    .exc_defer(exc_defer), .abort_p(abort_p), .stat_vld(stat_vld));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      summary();
    end
  end

  task automatic run_frame(input int hd, input int sp, input int en,
                           input int n, input int ctx, input int h);
    int gv = 0, gnh = 0, gd = 0, gx = 0, ga = 0;
    int e_exc, e_ab, e_def, e_nh;
    e_exc = (hd != 0 && n >= L) ? 1 : 0;
    e_ab  = (e_exc != 0 && en == 0) ? 1 : 0;
    e_def = (hd != 0 && n >= 1 && (e_ab != 0 || ctx == 0)) ? 1 : 0;
    e_nh  = (e_ab == 0 && sp != 0 && !(h >= 0 && h < W)) ? 1 : 0;

    @(negedge clk);
    half_duplex = hd[0]; speed_10 = sp[0]; tx_en_ctl = en[0];
    tx_req = 1; crs = (n > 0);
    @(negedge clk);
    tx_req = 0;
    // R8: flags cleared by the request
    chk("R8 no_hb", no_hb, 0);
    chk("R8 deferred", deferred, 0);
    chk("R8 exc_defer", exc_defer, 0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (stat_vld) begin
        gv = 1; gnh = no_hb; gd = deferred; gx = exc_defer; ga = abort_p;
        break;
      end
    end
    crs = 0;
    if (gv == 0) begin
      @(negedge clk);
      col = ctx[0];
      @(negedge clk);
      col = 0; tx_done = 1;
      @(negedge clk);
      tx_done = 0;
      if (sp == 0) begin
        // R3: status on the cycle after done
        chk("R3 stat_vld timing", stat_vld, 1);
        if (stat_vld) begin
          gv = 1; gnh = no_hb; gd = deferred; gx = exc_defer; ga = abort_p;
        end
      end else begin
        for (int j = 0; j < W + 3; j++) begin
          col = (j == h);
          @(negedge clk);
          col = 0;
          if (stat_vld) begin
            gv = 1; gnh = no_hb; gd = deferred; gx = exc_defer; ga = abort_p;
            // R2: window closes at the collision or the last tick
            chk("R2 window close", j, (h >= 0 && h < W) ? h : W - 1);
            break;
          end
        end
      end
    end
    chk("R9 stat_vld seen", gv, 1);
    chk("R2 no_hb", gnh, e_nh);
    chk("R4 deferred", gd, (hd != 0) ? e_def : 0);
    chk("R5 exc_defer", gx, e_exc);
    chk("R6 abort_p", ga, e_ab);
    // R9: strobe drops the next cycle
    @(negedge clk);
    chk("R9 stat_vld pulse", stat_vld, 0);
    if (hd == 0) chk("R7 full duplex flags", deferred | exc_defer, 0);
  endtask

  initial begin
    int ns[5];
    int hs[4];
    ns = '{0, 1, L-1, L, L+2};
    hs = '{-1, 0, W-1, W};
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 outputs", {no_hb, deferred, exc_defer, abort_p, stat_vld}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", {no_hb, deferred, exc_defer, abort_p, stat_vld}, 0);
    for (int hd = 0; hd < 2; hd++)
      for (int sp = 0; sp < 2; sp++)
        for (int en = 0; en < 2; en++)
          for (int a = 0; a < 5; a++)
            for (int c = 0; c < 2; c++)
              for (int b = 0; b < 4; b++)
                run_frame(hd, sp, en, ns[a], c, hs[b]);
    summary();
  end
endmodule